// File: doc/BRIEF.md
# Shared-Pin Digital Port with Converter Overrides

This block is an 8-bit general-purpose digital port whose pins are shared with the support functions of an analog converter. Software writes a pin-value register and a pin-direction register through a simple register interface and reads them back. The block drives an output enable and an output level to each pad. It samples every pad input through a synchronizer.

Two mode inputs from the converter's control logic can take over specific pins. In external-multiplexer mode, the two lowest pins become outputs that carry a 2-bit channel-select address. In trigger mode, two other pins become inputs whose synchronized levels are passed on as trigger signals. Each trigger pin has its own enable. Whenever a pin is taken over, a read of the pin-value register shows the override signal on that bit in place of the register-driven value.

Pins that will feed the converter as analog inputs must have their direction bits left at zero. A pin that is still driven as an output while it is being converted presents its own driven level to the converter.

Top module: `gpio_altfn_port`

## Requirements
- R1: While reset is asserted and after its release, the pin-value and pin-direction registers are all zeros, every `pad_oe` bit is 0 and `pad_out` is all zeros.
- R2: With no override active on a pin, `pad_oe[i]` equals direction bit i (1 = output, 0 = input), and `pad_out[i]` equals pin-value bit i.
- R3: A write with `wr_en`=1 updates the register chosen by `wr_sel` (0 = pin-value, 1 = direction) at the next rising clock edge, and the new value is visible on the pins and on readback in the cycle after that edge.
- R4: With `rd_sel`=0 and no override active on bit i, `rd_data[i]` returns pin-value bit i when the pin is an output. When the pin is an input, it returns the pad level sampled two clock edges earlier.
- R5: While external-multiplexer mode is in effect, pins 1:0 have `pad_oe`=1 and `pad_out[1:0]`=`mux_addr`, whatever their direction bits hold.
- R6: While external-multiplexer mode is in effect and `rd_sel`=0, `rd_data[1:0]` equals the current `mux_addr`.
- R7: While trigger enable 0 is in effect, pin 3 has `pad_oe`=0. While trigger enable 1 is in effect, pin 4 has `pad_oe`=0. Both hold whatever the direction bits say, and each enable acts on its own pin alone.
- R8: While a trigger enable is in effect, the matching `rd_data` bit (3 or 4, with `rd_sel`=0) and the matching `trig_out` bit return the twice-synchronized pad level. A trigger output whose enable is not in effect reads 0.
- R9: The mode inputs `xmux_en` and `trig_en` are registered. An override takes hold, and is released back to register control, in the cycle after the clock edge that samples the change.
- R10: With `rd_sel`=1, `rd_data` returns the direction register as written, unaffected by any override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 pin-value, 1 direction |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 pin-value view, 1 direction |
| rd_data | output | 8 | Read data (combinational) |
| xmux_en | input | 1 | External-multiplexer mode request |
| mux_addr | input | 2 | Multiplexer address driven on pins 1:0 |
| trig_en | input | 2 | Trigger mode requests for pins 3 and 4 |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| trig_out | output | 2 | Synchronized trigger levels for pins 3 and 4 |

## Verification
The bench builds the port with its default parameters: eight pins, the address pair at pins 1:0, the trigger pins at 3 and 4, and a two-stage synchronizer. These values let directed phases combine all three overrides with arbitrary direction patterns, including direction bits set on overridden pins. They also let the bench sweep all four address values and hold one trigger enable on alone while the other is off. A random phase then toggles modes, writes and pad levels together, so that takeover and release happen while pad data moves through the synchronizer.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } port_sel_e;

  localparam int MUX_BITS = 2;
  localparam int NUM_TRIG = 2;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  logic             data_we;
  logic             dir_we;
  logic [WIDTH-1:0] data_d;
  logic [WIDTH-1:0] dir_d;

  always_comb begin
    data_we = wr_en && (wr_sel == SEL_DATA);
    dir_we  = wr_en && (wr_sel == SEL_DIR);
    data_d  = data_we ? wr_data : data_q;
    dir_d   = dir_we  ? wr_data : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DATA) |=> (data_q == $past(wr_data))); // R3
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DIR) |=> (dir_q == $past(wr_data))); // R3
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];
  logic             past_ok_q;

  always_comb begin
    stage_d[0] = pad_in;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= '0;
      end
      past_ok_q <= 1'b0;
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= stage_d[k];
      end
      past_ok_q <= 1'b1;
    end
  end

  assign pad_sync = stage_q[STAGES-1];

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (stage_q[0] == $past(pad_in))); // R4
  if (STAGES > 1) begin : g_chain_chk
    AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok_q |-> (stage_q[STAGES-1] == $past(stage_q[STAGES-2]))); // R4
  end
endmodule

// File: rtl/gpio_pin_override.sv
module gpio_pin_override
  import gpio_port_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int MUX_LSB = 0,
  parameter int TRIG_A  = 3,
  parameter int TRIG_B  = 4
) (
  input  logic [WIDTH-1:0]    data_q,
  input  logic [WIDTH-1:0]    dir_q,
  input  logic [WIDTH-1:0]    pad_sync,
  input  logic                xmux_q,
  input  logic [NUM_TRIG-1:0] trig_q,
  input  logic [MUX_BITS-1:0] mux_addr,
  output logic [WIDTH-1:0]    pad_oe,
  output logic [WIDTH-1:0]    pad_out,
  output logic [WIDTH-1:0]    port_rd
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic is_mux;
    logic is_trig;
    logic mux_bit;

    if (i >= MUX_LSB && i < MUX_LSB + MUX_BITS) begin : g_mux_pin
      assign is_mux  = xmux_q;
      assign mux_bit = mux_addr[i-MUX_LSB];
    end else begin : g_plain_pin
      assign is_mux  = 1'b0;
      assign mux_bit = 1'b0;
    end

    if (i == TRIG_A) begin : g_trig_a
      assign is_trig = trig_q[0];
    end else if (i == TRIG_B) begin : g_trig_b
      assign is_trig = trig_q[1];
    end else begin : g_no_trig
      assign is_trig = 1'b0;
    end

    always_comb begin
      if (is_mux) begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = mux_bit;
        port_rd[i] = mux_bit;
      end else if (is_trig) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = data_q[i];
        port_rd[i] = pad_sync[i];
      end else begin
        pad_oe[i]  = dir_q[i];
        pad_out[i] = data_q[i];
        port_rd[i] = dir_q[i] ? data_q[i] : pad_sync[i];
      end
    end
  end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MUX_LSB     = 0,
  parameter int TRIG_A      = 3,
  parameter int TRIG_B      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [WIDTH-1:0]    wr_data,
  input  logic                rd_sel,
  output logic [WIDTH-1:0]    rd_data,
  input  logic                xmux_en,
  input  logic [MUX_BITS-1:0] mux_addr,
  input  logic [NUM_TRIG-1:0] trig_en,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    pad_oe,
  output logic [WIDTH-1:0]    pad_out,
  output logic [NUM_TRIG-1:0] trig_out
);
  localparam int MUX_MSB = MUX_LSB + MUX_BITS - 1;

  logic [WIDTH-1:0]    data_q;
  logic [WIDTH-1:0]    dir_q;
  logic [WIDTH-1:0]    pad_sync;
  logic [WIDTH-1:0]    port_rd;
  logic                xmux_q;
  logic                xmux_d;
  logic [NUM_TRIG-1:0] trig_q;
  logic [NUM_TRIG-1:0] trig_d;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pad_sync (pad_sync)
  );

  always_comb begin
    xmux_d = xmux_en;
    trig_d = trig_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xmux_q <= 1'b0;
      trig_q <= '0;
    end else begin
      xmux_q <= xmux_d;
      trig_q <= trig_d;
    end
  end

  gpio_pin_override #(
    .WIDTH   (WIDTH),
    .MUX_LSB (MUX_LSB),
    .TRIG_A  (TRIG_A),
    .TRIG_B  (TRIG_B)
  ) u_ovr (
    .data_q   (data_q),
    .dir_q    (dir_q),
    .pad_sync (pad_sync),
    .xmux_q   (xmux_q),
    .trig_q   (trig_q),
    .mux_addr (mux_addr),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .port_rd  (port_rd)
  );

  always_comb begin
    rd_data     = (rd_sel == SEL_DIR) ? dir_q : port_rd;
    trig_out[0] = trig_q[0] & pad_sync[TRIG_A];
    trig_out[1] = trig_q[1] & pad_sync[TRIG_B];
  end

  AST_MUX_FORCED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    xmux_en |=> (pad_oe[MUX_MSB:MUX_LSB] == '1)); // R5
  AST_MUX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    xmux_en |=> (rd_sel == SEL_DIR || rd_data[MUX_MSB:MUX_LSB] == mux_addr)); // R6
  AST_TRIG_A_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    trig_en[0] |=> !pad_oe[TRIG_A]); // R7
  AST_TRIG_B_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    trig_en[1] |=> !pad_oe[TRIG_B]); // R7
  AST_TRIG_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en[0] |=> !trig_out[0]); // R8
  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DIR) |=> (rd_sel == SEL_DATA || rd_data == $past(wr_data))); // R10
endmodule

// File: tb/tb_gpio_altfn_port.sv
`timescale 1ns/1ps
module tb_gpio_altfn_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       rd_sel;
  logic [7:0] rd_data;
  logic       xmux_en;
  logic [1:0] mux_addr;
  logic [1:0] trig_en;
  logic [7:0] pad_in;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;
  logic [1:0] trig_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_data, m_dir, m_s1, m_s2;
  logic       m_x;
  logic [1:0] m_t;

  always #2 clk = ~clk;

  gpio_altfn_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .xmux_en(xmux_en), .mux_addr(mux_addr),
    .trig_en(trig_en), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .trig_out(trig_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_oe, e_out, e_rd;
    logic [1:0] e_trig;
    for (int i = 0; i < 8; i++) begin
      bit mx = m_x && (i < 2);
      bit tg = (i == 3 && m_t[0]) || (i == 4 && m_t[1]);
      if (mx) begin
        e_oe[i] = 1'b1; e_out[i] = mux_addr[i]; e_rd[i] = mux_addr[i];
      end else if (tg) begin
        e_oe[i] = 1'b0; e_out[i] = m_data[i]; e_rd[i] = m_s2[i];
      end else begin
        e_oe[i] = m_dir[i]; e_out[i] = m_data[i];
        e_rd[i] = m_dir[i] ? m_data[i] : m_s2[i];
      end
    end
    if (rd_sel) e_rd = m_dir;
    e_trig[0] = m_t[0] & m_s2[3];
    e_trig[1] = m_t[1] & m_s2[4];
    chk("R2 R5 R7 R9 pad_oe", pad_oe, e_oe);
    chk("R2 R5 pad_out", pad_out, e_out);
    chk("R3 R4 R6 R8 R10 rd_data", rd_data, e_rd);
    chk("R8 trig_out", {6'b0, trig_out}, {6'b0, e_trig});
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    if (wr_en && !wr_sel) m_data = wr_data;
    if (wr_en &&  wr_sel) m_dir  = wr_data;
    m_s2 = m_s1;
    m_s1 = pad_in;
    m_x  = xmux_en;
    m_t  = trig_en;
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    xmux_en = 0; mux_addr = 0; trig_en = 0; pad_in = 8'h00;
    m_data = 0; m_dir = 0; m_s1 = 0; m_s2 = 0; m_x = 0; m_t = 0;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    pad_in = 8'h5A;
    #1;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    rd_sel = 1;
    #0 chk("R1 dir", rd_data, 8'h00);
    rd_sel = 0;
    pad_in = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    // R2, R3: direction and data writes
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'hA5);
    step();
    // R4: input pins follow the synchronized pads
    pad_in = 8'h3C; step(); step(); step();
    pad_in = 8'hC3; step(); step(); step();
    // R10: direction readback
    rd_sel = 1; step(); rd_sel = 0;
    // R5, R6, R9: external multiplexer mode with direction bits clear
    xmux_en = 1;
    for (int a = 0; a < 4; a++) begin mux_addr = a[1:0]; step(); end
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h00);
    for (int a = 3; a >= 0; a--) begin mux_addr = a[1:0]; step(); end
    rd_sel = 1; step(); rd_sel = 0;
    xmux_en = 0; step(); step();
    // R7, R8: trigger enables alone and together, direction all ones
    trig_en = 2'b01; pad_in = 8'h08; step(); step(); step();
    pad_in = 8'h10; step(); step(); step();
    trig_en = 2'b10; step(); step(); step();
    pad_in = 8'h18; trig_en = 2'b11; step(); step(); step();
    trig_en = 2'b00; step(); step();
    // random mix of every input
    for (int n = 0; n < 600; n++) begin
      wr_en    = ($urandom % 4) == 0;
      wr_sel   = $urandom % 2;
      wr_data  = 8'($urandom);
      rd_sel   = ($urandom % 4) == 0;
      xmux_en  = ($urandom % 3) == 0;
      mux_addr = 2'($urandom);
      trig_en  = 2'($urandom);
      pad_in   = 8'($urandom);
      step();
    end
    wr_en = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule